// File: doc/BRIEF.md
# Sixteen-Pin GPIO Register Bank

This block holds the control and status registers behind a sixteen-pin bidirectional port, organised as two eight-bit ports. A simple byte-wide access port (strobes, a three-bit address, write data and registered read data) reaches eight byte registers: per port, one read-only input view, one output latch, one read-polarity mask and one direction register. The block drives an output value and an output enable for every pin, and returns pin levels on read after passing them through a two-flop synchronizer and the per-bit polarity mask.

The address splits into a register kind in its upper two bits and a port select in its lowest bit. Reading a port's input view also raises a one-cycle latch pulse for that port, marking the moment its pin snapshot was taken. Pad cells, pull-ups, drive strength and the serial bus that issues the byte accesses sit outside this block.

Top module: `gpio16_regbank`

## Requirements
- R1: Address bits [2:1] select the register kind (0 input view, 1 output latch, 2 polarity mask, 3 direction) and bit [0] selects the port (0 drives pins [7:0], 1 drives pins [15:8]); so addresses 0..7 are input0, input1, out0, out1, pol0, pol1, dir0, dir1.
- R2: A write to address 0 or 1 changes nothing: no pin output, no output enable and no readable register.
- R3: Reading an input view returns the synchronized level of that port's pins whether each pin is an input or an output.
- R4: On an input-view read, each bit whose polarity-mask bit is 1 is returned inverted; a 0 mask bit returns the level unchanged.
- R5: A direction bit of 1 holds the pin's output enable low; a 0 raises the output enable and the pin drives its output-latch bit.
- R6: After reset the output latches and direction registers read 8'hFF, the polarity masks read 8'h00, every output enable is low, pin_out is all ones, rd_data is 0 and no latch pulse is high.
- R7: Reading an output latch returns the stored byte, not the pin level.
- R8: A write updates only the addressed byte, on the clock edge where wr_en is sampled high, and a new output or direction byte is visible on pin_out / pin_oe right after that edge.
- R9: A read of input view p raises in_latch[p] for exactly the one cycle in which rd_data carries that read; other reads leave in_latch at zero.
- R10: A pin level change reaches reads through two flops: reads sampled on the first and second clock edges after the change return the old level, the third returns the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 3 | Register address: kind in [2:1], port in [0] |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte, updated the cycle after rd_en |
| in_latch | output | 2 | One-cycle input snapshot pulse, one bit per port |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| pin_out | output | 16 | Output latch value per pin |
| pin_oe | output | 16 | Output enable per pin, high = drive |

## Verification
The assertions take the access strobes to be clean synchronous one-cycle pulses with a stable address and data, and they treat a read and a write in the same cycle as legal but read-before-write; they place no constraint on pin_in, which may change in any cycle. The stimulus changes every strobe and address half a period away from the sampling edge and holds pin_in steady for at least three cycles before any read whose value is checked, except in the synchronizer-latency test, where the pin change and the read are launched together on purpose to observe the two-cycle delay.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  typedef enum logic [1:0] {
    RK_IN  = 2'd0,
    RK_OUT = 2'd1,
    RK_POL = 2'd2,
    RK_DIR = 2'd3
  } reg_kind_e;

  localparam logic OUT_RESET_BIT = 1'b1;
  localparam logic POL_RESET_BIT = 1'b0;
  localparam logic DIR_RESET_BIT = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio16_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  reg_kind_e         kind,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= {PORT_W{OUT_RESET_BIT}};
      pol_q <= {PORT_W{POL_RESET_BIT}};
      dir_q <= {PORT_W{DIR_RESET_BIT}};
    end else if (wr_sel) begin
      case (kind)
        RK_OUT:  out_q <= wr_data;
        RK_POL:  pol_q <= wr_data;
        RK_DIR:  dir_q <= wr_data;
        default: ;
      endcase
    end
  end

  // R2: input-kind writes leave every held byte untouched
  p_in_kind_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && kind == RK_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio16_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NPORTS = 2,
  parameter int PSEL_W = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  reg_kind_e                     kind,
  input  logic [PSEL_W-1:0]             psel,
  input  logic [NPORTS-1:0][PORT_W-1:0] pin_s,
  input  logic [NPORTS-1:0][PORT_W-1:0] out_a,
  input  logic [NPORTS-1:0][PORT_W-1:0] pol_a,
  input  logic [NPORTS-1:0][PORT_W-1:0] dir_a,
  output logic [PORT_W-1:0]             rd_data,
  output logic [NPORTS-1:0]             in_latch
);
  logic [PORT_W-1:0] sel_byte;
  logic [NPORTS-1:0] latch_d;

  always_comb begin
    sel_byte = '0;
    latch_d  = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (psel == PSEL_W'(p)) begin
        case (kind)
          RK_IN: begin
            sel_byte   = pin_s[p] ^ pol_a[p];
            latch_d[p] = rd_en;
          end
          RK_OUT:  sel_byte = out_a[p];
          RK_POL:  sel_byte = pol_a[p];
          default: sel_byte = dir_a[p];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      in_latch <= '0;
    end else begin
      in_latch <= latch_d;
      if (rd_en) rd_data <= sel_byte;
    end
  end

  // R9: at most one port snapshots at a time
  p_latch_single_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(in_latch));
  // R9: latch pulse never outlives the read that caused it
  p_latch_needs_read_r9: assert property (@(posedge clk) disable iff (rst)
    (in_latch != '0) |-> $past(rd_en));
endmodule

// File: rtl/gpio16_regbank.sv
module gpio16_regbank
  import gpio16_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NPORTS    = 2,
  parameter int SYNC_STG  = 2,
  localparam int PSEL_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int ADDR_W   = 2 + PSEL_W,
  localparam int PIN_W    = PORT_W * NPORTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data,
  output logic [NPORTS-1:0] in_latch,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  reg_kind_e                     kind;
  logic [PSEL_W-1:0]             psel;
  logic [PIN_W-1:0]              pin_sync;
  logic [NPORTS-1:0][PORT_W-1:0] pin_s;
  logic [NPORTS-1:0][PORT_W-1:0] out_a;
  logic [NPORTS-1:0][PORT_W-1:0] pol_a;
  logic [NPORTS-1:0][PORT_W-1:0] dir_a;

  assign kind = reg_kind_e'(addr[ADDR_W-1 -: 2]);
  assign psel = addr[PSEL_W-1:0];

  gpio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign pin_s[p] = pin_sync[p*PORT_W +: PORT_W];

    gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (wr_en && (psel == PSEL_W'(p))),
      .kind    (kind),
      .wr_data (wr_data),
      .out_q   (out_a[p]),
      .pol_q   (pol_a[p]),
      .dir_q   (dir_a[p])
    );

    assign pin_out[p*PORT_W +: PORT_W] = out_a[p];
    assign pin_oe[p*PORT_W +: PORT_W]  = ~dir_a[p];

    // R8: output byte reaches its pins on the write edge
    p_out_write_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && kind == RK_OUT && psel == PSEL_W'(p))
        |=> pin_out[p*PORT_W +: PORT_W] == $past(wr_data));
    // R5: direction 0 drives, 1 releases
    p_dir_write_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && kind == RK_DIR && psel == PSEL_W'(p))
        |=> pin_oe[p*PORT_W +: PORT_W] == ~$past(wr_data));
    // R8: a byte not addressed keeps its enables
    p_dir_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && kind == RK_DIR && psel == PSEL_W'(p))
        |=> $stable(pin_oe[p*PORT_W +: PORT_W]));
    // R7: output read returns latch contents
    p_out_read_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && kind == RK_OUT && psel == PSEL_W'(p))
        |=> rd_data == $past(pin_out[p*PORT_W +: PORT_W]));
    // R9: input read of this port fires its latch pulse
    p_latch_fire_r9: assert property (@(posedge clk) disable iff (rst)
      (rd_en && kind == RK_IN && psel == PSEL_W'(p)) |=> in_latch[p]);
  end

  gpio_read_mux #(.PORT_W(PORT_W), .NPORTS(NPORTS), .PSEL_W(PSEL_W)) u_rmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .kind     (kind),
    .psel     (psel),
    .pin_s    (pin_s),
    .out_a    (out_a),
    .pol_a    (pol_a),
    .dir_a    (dir_a),
    .rd_data  (rd_data),
    .in_latch (in_latch)
  );

  // R2: input-kind writes never move the pins
  p_in_write_pins_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == RK_IN) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/sim_gpio16_regbank.sv
module sim_gpio16_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [1:0]  in_latch;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpio16_regbank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .in_latch(in_latch),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #4ns clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d, output logic [1:0] lt);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; lt = in_latch;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [1:0] lt;
    check("R6 rd_data", 32'(rd_data), 32'h00);
    check("R6 oe", 32'(pin_oe), 32'h0000);
    check("R6 out", 32'(pin_out), 32'hFFFF);
    check("R6 latch", 32'(in_latch), 32'h0);
    do_read(3'd2, d, lt); check("R6 out0", 32'(d), 32'hFF);
    do_read(3'd5, d, lt); check("R6 pol1", 32'(d), 32'h00);
    do_read(3'd7, d, lt); check("R6 dir1", 32'(d), 32'hFF);
  endtask

  task automatic t_write_dir();
    logic [7:0] d; logic [1:0] lt;
    do_write(3'd2, 8'hA5);
    check("R8 out0 pins", 32'(pin_out), 32'hFFA5);
    check("R5 out ignored while input", 32'(pin_oe), 32'h0000);
    do_read(3'd2, d, lt); check("R7 out0 read", 32'(d), 32'hA5);
    do_write(3'd6, 8'h0F);
    check("R5 dir0 oe", 32'(pin_oe), 32'h00F0);
    do_write(3'd3, 8'h3C);
    do_write(3'd7, 8'h00);
    check("R8 out1 only", 32'(pin_out), 32'h3CA5);
    check("R5 dir1 oe", 32'(pin_oe), 32'hFFF0);
    do_read(3'd6, d, lt); check("R1 dir0 addr6", 32'(d), 32'h0F);
    do_read(3'd3, d, lt); check("R7 out1 read", 32'(d), 32'h3C);
  endtask

  task automatic t_input_read();
    logic [7:0] d; logic [1:0] lt;
    pin_in = 16'h5AC3;
    settle();
    do_read(3'd0, d, lt);
    check("R3 in0 mixed dir", 32'(d), 32'hC3);
    check("R9 latch port0", 32'(lt), 32'h1);
    do_read(3'd1, d, lt);
    check("R3 in1 while output", 32'(d), 32'h5A);
    check("R9 latch port1", 32'(lt), 32'h2);
    do_read(3'd2, d, lt);
    check("R9 no latch on out read", 32'(lt), 32'h0);
    check("R7 out0 not pins", 32'(d), 32'hA5);
    @(negedge clk);
    check("R9 latch one cycle", 32'(in_latch), 32'h0);
  endtask

  task automatic t_polarity();
    logic [7:0] d; logic [1:0] lt;
    do_write(3'd4, 8'hFF);
    do_write(3'd5, 8'h0F);
    do_read(3'd0, d, lt); check("R4 in0 inverted", 32'(d), 32'h3C);
    do_read(3'd1, d, lt); check("R4 in1 partial", 32'(d), 32'h55);
    do_read(3'd4, d, lt); check("R1 pol0 read", 32'(d), 32'hFF);
    do_write(3'd4, 8'h00);
    do_write(3'd5, 8'h00);
    do_read(3'd0, d, lt); check("R4 mask cleared", 32'(d), 32'hC3);
  endtask

  task automatic t_input_write_ignored();
    logic [7:0] d; logic [1:0] lt;
    do_write(3'd0, 8'h00);
    do_write(3'd1, 8'hFF);
    check("R2 pins unchanged", 32'(pin_out), 32'h3CA5);
    check("R2 oe unchanged", 32'(pin_oe), 32'hFFF0);
    do_read(3'd4, d, lt); check("R2 pol0 unchanged", 32'(d), 32'h00);
    do_read(3'd7, d, lt); check("R2 dir1 unchanged", 32'(d), 32'h00);
    do_read(3'd0, d, lt); check("R2 in0 still pins", 32'(d), 32'hC3);
  endtask

  task automatic t_sync_latency();
    @(negedge clk);
    pin_in = 16'h5A3E;
    rd_en = 1'b1; addr = 3'd0;
    @(negedge clk);
    check("R10 edge1 old", 32'(rd_data), 32'hC3);
    @(negedge clk);
    check("R10 edge2 old", 32'(rd_data), 32'hC3);
    @(negedge clk);
    rd_en = 1'b0;
    check("R10 edge3 new", 32'(rd_data), 32'h3E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_dir();
    t_input_read();
    t_polarity();
    t_input_write_ignored();
    t_sync_latency();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule